// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between the operand fields of a small 8-bit processor core and its data storage. Each instruction supplies an 8-bit operand address. The block joins that operand with a 4-bit bank register to reach a 4096-byte data space of sixteen 256-byte banks. An access-window mode reaches two fixed regions without using the bank register. Operands with the top bit clear select the bottom half of bank 0. Operands with the top bit set select the top half of bank 15, which holds the special-function registers. A move operation carries two full 12-bit addresses. It reads its source in one cycle and writes its destination in the next.

General-purpose RAM exists only for the banks selected by a mask parameter. Reads from a missing bank return zero, and writes to a missing bank are dropped. The completion pulse still fires in both cases, so status logic elsewhere in the core carries on as if the access had worked. Accesses to the special-function region leave on an external port. The one exception is the bank register itself, which lives at a fixed address in that region and is handled internally.

Top module: `banked_mem_unit`

## Requirements
- R1: With `acc_mode` low, the data address is the bank register value (bits 11:8) joined to `op_addr` (bits 7:0); data written there reads back only under the same bank value.
- R2: With `acc_mode` high and `op_addr` below 80h, the access targets 000h–07Fh in bank 0 whatever the bank register holds.
- R3: Any address in F80h–FFFh (access mode with `op_addr` 80h–FFh, or normal mode with bank 15 and `op_addr` 80h–FFh) goes to the SFR port with `sfr_addr` equal to address bits 6:0, and `rd_data` returns the `sfr_rdata` value sampled in the request cycle. The bank register address is the exception.
- R4: A pulse on `mv_start` reads the full 12-bit `mv_src` in that cycle and writes the byte to the full 12-bit `mv_dst` in the next cycle. `done` is low one cycle after the request and high two cycles after it. The bank register plays no part.
- R5: A write whose address lies in an unimplemented bank (mask bit 0, outside F80h–FFFh) changes no stored byte in any bank.
- R6: A read from an unimplemented bank returns 00h, with `bank_present` low alongside `done`.
- R7: `done` is high exactly one cycle after every single read or write request, including those to unimplemented banks, and low after idle cycles and out of reset. `bank_present` is high with it for implemented banks and for F80h–FFFh.
- R8: The bank register sits at address FE0h (access-mode operand E0h). Writes load data bits 3:0, and reads return those bits with bits 7:4 zero. It clears to 0 on reset.
- R9: Read data and `rd_valid` appear one cycle after `rd_en`. When `rd_en` and `wr_en` are high together, the read returns the byte held before that write.
- R10: The move destination obeys the same rules as a single write. It is dropped in an unimplemented bank, reported through `bank_present` low with `done`, and loads the bank register when it is FE0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_addr | input | 8 | Operand address from the instruction |
| acc_mode | input | 1 | 1 selects the access window, 0 uses the bank register |
| rd_en | input | 1 | Read request for the operand address |
| wr_en | input | 1 | Write request for the operand address |
| wr_data | input | 8 | Write data |
| mv_start | input | 1 | Start of a two-cycle move |
| mv_src | input | 12 | Full move source address |
| mv_dst | input | 12 | Full move destination address |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result valid for a single read |
| done | output | 1 | Access completed |
| bank_present | output | 1 | Target storage exists, valid with done |
| sfr_addr | output | 7 | Offset into the special-function region |
| sfr_re | output | 1 | Special-function read strobe |
| sfr_we | output | 1 | Special-function write strobe |
| sfr_wdata | output | 8 | Special-function write data |
| sfr_rdata | input | 8 | Special-function read data, sampled at the request edge |

## Verification
The hardest case to reach is a move whose destination is not a RAM byte. When the destination is a missing bank or the bank register, the outcome is invisible until a later, separate access looks for it. The stimulus first plants known bytes in implemented banks. It then moves them into the bank register and into an unimplemented bank, and reads back the bank register, the missing bank and the neighbouring implemented bank to show that only the intended effect happened. The bank register is set to an unimplemented bank before the first move, so any dependence on it would misroute the move.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
   // Source of the byte presented on the read-data output
   typedef enum logic [1:0] {
      SRC_ZERO    = 2'd0,
      SRC_RAM     = 2'd1,
      SRC_SFR     = 2'd2,
      SRC_BANKREG = 2'd3
   } rd_src_e;
endpackage

// File: rtl/bmu_addr_gen.sv
module bmu_addr_gen #(
   parameter int OFFS_W = 8,
   parameter int BANK_W = 4,
   localparam int ADDR_W = OFFS_W + BANK_W
) (
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [OFFS_W-1:0] op_addr,
   input  logic              acc_mode,
   output logic [ADDR_W-1:0] full_addr
);
   // Access window: top operand bit replicated picks bank 0 or the top bank
   assign full_addr = acc_mode ? {{BANK_W{op_addr[OFFS_W-1]}}, op_addr}
                               : {bank_sel, op_addr};
endmodule

// File: rtl/bmu_region_dec.sv
module bmu_region_dec #(
   parameter int OFFS_W = 8,
   parameter int BANK_W = 4,
   localparam int ADDR_W = OFFS_W + BANK_W,
   localparam int NBANK  = 2 ** BANK_W,
   parameter logic [NBANK-1:0]  BANK_MASK    = 16'h8003,
   parameter logic [ADDR_W-1:0] BANKREG_ADDR = 12'hFE0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank_idx,
   output logic              is_sfr,
   output logic              is_bankreg,
   output logic              bank_impl
);
   assign bank_idx   = addr[ADDR_W-1:OFFS_W];
   assign is_sfr     = &addr[ADDR_W-1:OFFS_W-1];
   assign is_bankreg = (addr == BANKREG_ADDR);
   assign bank_impl  = BANK_MASK[bank_idx];
endmodule

// File: rtl/bmu_bank_ram.sv
module bmu_bank_ram #(
   parameter int DATA_W = 8,
   parameter int AW     = 8,
   localparam int DEPTH = 2 ** AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   // Registered read sees the contents before a same-edge write
   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
   end
endmodule

// File: rtl/banked_mem_unit.sv
module banked_mem_unit
   import bmu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFFS_W = 8,
   parameter int BANK_W = 4,
   localparam int ADDR_W = OFFS_W + BANK_W,
   localparam int NBANK  = 2 ** BANK_W,
   localparam int SFR_W  = OFFS_W - 1,
   parameter logic [NBANK-1:0]  BANK_MASK    = 16'h8003,
   parameter logic [ADDR_W-1:0] BANKREG_ADDR = 12'hFE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFFS_W-1:0] op_addr,
   input  logic              acc_mode,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mv_start,
   input  logic [ADDR_W-1:0] mv_src,
   input  logic [ADDR_W-1:0] mv_dst,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              bank_present,
   output logic [SFR_W-1:0]  sfr_addr,
   output logic              sfr_re,
   output logic              sfr_we,
   output logic [DATA_W-1:0] sfr_wdata,
   input  logic [DATA_W-1:0] sfr_rdata
);
   // Elaboration-time parameter checks
   if (DATA_W < BANK_W) begin : g_chk_data_w
      $error("DATA_W must hold a full bank number");
   end
   if (OFFS_W < 2) begin : g_chk_offs_w
      $error("OFFS_W must be at least 2");
   end
   if (!(&BANKREG_ADDR[ADDR_W-1:OFFS_W-1])) begin : g_chk_breg
      $error("BANKREG_ADDR must lie in the special-function region");
   end

   // State
   logic [BANK_W-1:0] bank_q;
   logic              mv_ph2_q;
   logic [ADDR_W-1:0] mv_dst_q;
   logic              mv_src_ok_q;
   rd_src_e           rd_src_q;
   logic [BANK_W-1:0] rd_bank_q;
   logic [DATA_W-1:0] sfr_rdata_q;
   logic [BANK_W-1:0] breg_rd_q;
   logic              done_q, rd_valid_q, present_q;

   // Access selection
   logic [ADDR_W-1:0] op_full, acc_addr;
   logic              acc_rd, acc_wr;
   logic [DATA_W-1:0] acc_wdata, rd_result;
   logic [BANK_W-1:0] bank_idx;
   logic              is_sfr, is_bankreg, bank_impl, gpr_hit, present;
   logic [DATA_W-1:0] ram_rdata [NBANK];

   bmu_addr_gen #(.OFFS_W(OFFS_W), .BANK_W(BANK_W)) u_agen (
      .bank_sel (bank_q),
      .op_addr  (op_addr),
      .acc_mode (acc_mode),
      .full_addr(op_full)
   );

   always_comb begin
      if (mv_ph2_q) begin
         acc_addr  = mv_dst_q;
         acc_rd    = 1'b0;
         acc_wr    = 1'b1;
         acc_wdata = rd_result;
      end else if (mv_start) begin
         acc_addr  = mv_src;
         acc_rd    = 1'b1;
         acc_wr    = 1'b0;
         acc_wdata = wr_data;
      end else begin
         acc_addr  = op_full;
         acc_rd    = rd_en;
         acc_wr    = wr_en;
         acc_wdata = wr_data;
      end
   end

   bmu_region_dec #(
      .OFFS_W(OFFS_W), .BANK_W(BANK_W),
      .BANK_MASK(BANK_MASK), .BANKREG_ADDR(BANKREG_ADDR)
   ) u_dec (
      .addr      (acc_addr),
      .bank_idx  (bank_idx),
      .is_sfr    (is_sfr),
      .is_bankreg(is_bankreg),
      .bank_impl (bank_impl)
   );

   assign gpr_hit = !is_sfr && bank_impl;
   assign present = is_sfr || bank_impl;

   // One RAM per implemented bank; missing banks read as zero
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      if (BANK_MASK[b]) begin : g_ram
         logic sel;
         assign sel = gpr_hit && (bank_idx == BANK_W'(b));
         bmu_bank_ram #(.DATA_W(DATA_W), .AW(OFFS_W)) u_ram (
            .clk  (clk),
            .we   (acc_wr && sel),
            .re   (acc_rd && sel),
            .addr (acc_addr[OFFS_W-1:0]),
            .wdata(acc_wdata),
            .rdata(ram_rdata[b])
         );
      end else begin : g_none
         assign ram_rdata[b] = '0;
      end
   end

   // Special-function port, bank register excluded
   assign sfr_addr  = acc_addr[SFR_W-1:0];
   assign sfr_re    = acc_rd && is_sfr && !is_bankreg;
   assign sfr_we    = acc_wr && is_sfr && !is_bankreg;
   assign sfr_wdata = acc_wdata;

   always_comb begin
      case (rd_src_q)
         SRC_RAM:     rd_result = ram_rdata[rd_bank_q];
         SRC_SFR:     rd_result = sfr_rdata_q;
         SRC_BANKREG: rd_result = {{(DATA_W-BANK_W){1'b0}}, breg_rd_q};
         default:     rd_result = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q      <= '0;
         mv_ph2_q    <= 1'b0;
         mv_dst_q    <= '0;
         mv_src_ok_q <= 1'b0;
         rd_src_q    <= SRC_ZERO;
         rd_bank_q   <= '0;
         sfr_rdata_q <= '0;
         breg_rd_q   <= '0;
         done_q      <= 1'b0;
         rd_valid_q  <= 1'b0;
         present_q   <= 1'b0;
      end else begin
         if (acc_wr && is_bankreg) bank_q <= acc_wdata[BANK_W-1:0];
         mv_ph2_q <= !mv_ph2_q && mv_start;
         if (!mv_ph2_q && mv_start) begin
            mv_dst_q    <= mv_dst;
            mv_src_ok_q <= present;
         end
         if (acc_rd) begin
            rd_bank_q <= bank_idx;
            breg_rd_q <= bank_q;
            if (is_bankreg)   rd_src_q <= SRC_BANKREG;
            else if (is_sfr)  rd_src_q <= SRC_SFR;
            else if (bank_impl) rd_src_q <= SRC_RAM;
            else              rd_src_q <= SRC_ZERO;
         end
         if (sfr_re) sfr_rdata_q <= sfr_rdata;
         done_q     <= mv_ph2_q || (!mv_start && (rd_en || wr_en));
         rd_valid_q <= !mv_ph2_q && !mv_start && rd_en;
         present_q  <= mv_ph2_q ? (present && mv_src_ok_q) : present;
      end
   end

   assign rd_data      = rd_result;
   assign rd_valid     = rd_valid_q;
   assign done         = done_q;
   assign bank_present = present_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
   import bmu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic              mv_start,
   input logic              mv_ph2_q,
   input rd_src_e           rd_src_q,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              done,
   input logic              bank_present,
   input logic              sfr_re
);
   AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mv_ph2_q && !mv_start && (rd_en || wr_en)) |=> done); // R7

   AST_NO_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mv_ph2_q && !mv_start && !rd_en && !wr_en) |=> !done); // R7

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mv_ph2_q && !mv_start && rd_en) |=> rd_valid); // R9

   AST_MOVE_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_start && !mv_ph2_q) |=> (mv_ph2_q && !done && !rd_valid)); // R4

   AST_MOVE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      mv_ph2_q |=> (done && !mv_ph2_q)); // R4

   AST_MOVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mv_ph2_q |-> !sfr_re); // R10

   AST_MISSING_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !bank_present) |-> (rd_data == '0)); // R6

   AST_BANKREG_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_src_q == SRC_BANKREG) |-> (rd_data[DATA_W-1:BANK_W] == '0)); // R8
endmodule

bind banked_mem_unit bmu_checker #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/banked_mem_unit_tb.sv
`timescale 1ns/1ps
module banked_mem_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_addr = '0;
   logic        acc_mode = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        mv_start = 1'b0;
   logic [11:0] mv_src = '0, mv_dst = '0;
   logic [7:0]  rd_data;
   logic        rd_valid, done, bank_present;
   logic [6:0]  sfr_addr;
   logic        sfr_re, sfr_we;
   logic [7:0]  sfr_wdata, sfr_rdata;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   // Special-function responder: returns its offset with bit 7 set
   assign sfr_rdata = {1'b1, sfr_addr};

   banked_mem_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .acc_mode(acc_mode),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst),
      .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
      .bank_present(bank_present), .sfr_addr(sfr_addr), .sfr_re(sfr_re),
      .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One request cycle; outputs sampled at the following falling edge
   task automatic access(input logic am, input logic [7:0] op, input logic r, input logic w,
                         input logic [7:0] wd, output logic [7:0] rdat, output logic dn,
                         output logic pres, output logic rv);
      @(negedge clk);
      acc_mode = am; op_addr = op; rd_en = r; wr_en = w; wr_data = wd;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      rdat = rd_data; dn = done; pres = bank_present; rv = rd_valid;
   endtask

   task automatic put(input logic am, input logic [7:0] op, input logic [7:0] d);
      logic [7:0] x; logic a, b, c;
      access(am, op, 1'b0, 1'b1, d, x, a, b, c);
   endtask

   task automatic get(input logic am, input logic [7:0] op, output logic [7:0] d);
      logic a, b, c;
      access(am, op, 1'b1, 1'b0, 8'h00, d, a, b, c);
   endtask

   task automatic set_bank(input logic [7:0] b);
      put(1'b1, 8'hE0, b);
   endtask

   task automatic move(input logic [11:0] s, input logic [11:0] d,
                       output logic dn_mid, output logic dn, output logic pres);
      @(negedge clk);
      mv_start = 1'b1; mv_src = s; mv_dst = d;
      @(negedge clk);
      mv_start = 1'b0;
      dn_mid = done;
      @(negedge clk);
      dn = done; pres = bank_present;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R7 done low out of reset", {31'd0, done}, 32'd0);
      check("R7 rd_valid low out of reset", {31'd0, rd_valid}, 32'd0);
      get(1'b1, 8'hE0, d);
      check("R8 bank register resets to 0", {24'd0, d}, 32'h00);
   endtask

   task automatic t_normal();
      logic [7:0] d;
      set_bank(8'h01); put(1'b0, 8'h33, 8'hA5);
      set_bank(8'h00); put(1'b0, 8'h33, 8'h5A);
      set_bank(8'h01); get(1'b0, 8'h33, d);
      check("R1 bank 1 offset 33h", {24'd0, d}, 32'hA5);
      set_bank(8'h00); get(1'b0, 8'h33, d);
      check("R1 bank 0 offset 33h", {24'd0, d}, 32'h5A);
      set_bank(8'h0F); put(1'b0, 8'h10, 8'h44); get(1'b0, 8'h10, d);
      check("R1 bank 15 general byte F10h", {24'd0, d}, 32'h44);
   endtask

   task automatic t_access_low();
      logic [7:0] d;
      set_bank(8'h01);
      put(1'b1, 8'h20, 8'h77);
      get(1'b1, 8'h20, d);
      check("R2 access low half ignores bank register", {24'd0, d}, 32'h77);
      set_bank(8'h00); get(1'b0, 8'h20, d);
      check("R2 access low half landed in bank 0", {24'd0, d}, 32'h77);
   endtask

   task automatic t_sfr();
      logic [7:0] d;
      logic we_s, re_s; logic [6:0] a_s; logic [7:0] wd_s;
      set_bank(8'h01);
      @(negedge clk);
      acc_mode = 1'b1; op_addr = 8'h90; wr_en = 1'b1; wr_data = 8'h3C;
      #1; we_s = sfr_we; re_s = sfr_re; a_s = sfr_addr; wd_s = sfr_wdata;
      @(negedge clk);
      wr_en = 1'b0;
      check("R3 access high write strobes SFR port", {30'd0, we_s, re_s}, 32'h2);
      check("R3 SFR offset", {25'd0, a_s}, 32'h10);
      check("R3 SFR write data", {24'd0, wd_s}, 32'h3C);
      get(1'b1, 8'h85, d);
      check("R3 access high read from SFR port", {24'd0, d}, 32'h85);
      set_bank(8'h0F); get(1'b0, 8'hC2, d);
      check("R3 bank 15 upper half is SFR", {24'd0, d}, 32'hC2);
   endtask

   task automatic t_bankreg();
      logic [7:0] d;
      set_bank(8'hF7); get(1'b1, 8'hE0, d);
      check("R8 bank register upper bits read zero", {24'd0, d}, 32'h07);
   endtask

   task automatic t_unimpl();
      logic [7:0] d; logic dn, pres, rv;
      set_bank(8'h00); put(1'b0, 8'h10, 8'h11);
      set_bank(8'h01); put(1'b0, 8'h10, 8'h22);
      set_bank(8'h02);
      access(1'b0, 8'h10, 1'b0, 1'b1, 8'hEE, d, dn, pres, rv);
      check("R7 done after write to missing bank", {31'd0, dn}, 32'd1);
      check("R7 write to missing bank not present", {31'd0, pres}, 32'd0);
      access(1'b0, 8'h10, 1'b1, 1'b0, 8'h00, d, dn, pres, rv);
      check("R6 read of missing bank is zero", {24'd0, d}, 32'h00);
      check("R6 bank_present low on missing bank", {31'd0, pres}, 32'd0);
      check("R7 done after read of missing bank", {31'd0, dn}, 32'd1);
      set_bank(8'h00); get(1'b0, 8'h10, d);
      check("R5 bank 0 untouched by dropped write", {24'd0, d}, 32'h11);
      set_bank(8'h01); access(1'b0, 8'h10, 1'b1, 1'b0, 8'h00, d, dn, pres, rv);
      check("R5 bank 1 untouched by dropped write", {24'd0, d}, 32'h22);
      check("R7 bank_present high on implemented bank", {31'd0, pres}, 32'd1);
   endtask

   task automatic t_rmw();
      logic [7:0] d; logic dn, pres, rv;
      set_bank(8'h00); put(1'b0, 8'h40, 8'h01);
      access(1'b0, 8'h40, 1'b1, 1'b1, 8'h02, d, dn, pres, rv);
      check("R9 read with same-cycle write gives old byte", {24'd0, d}, 32'h01);
      check("R9 rd_valid one cycle after read", {31'd0, rv}, 32'd1);
      get(1'b0, 8'h40, d);
      check("R9 write took effect", {24'd0, d}, 32'h02);
   endtask

   task automatic t_move();
      logic [7:0] d; logic mid, dn, pres;
      set_bank(8'h00); put(1'b0, 8'h50, 8'hC3); put(1'b0, 8'h60, 8'h99);
      set_bank(8'h02);
      move(12'h050, 12'h1F0, mid, dn, pres);
      check("R4 done low one cycle after move", {31'd0, mid}, 32'd0);
      check("R4 done high two cycles after move", {31'd0, dn}, 32'd1);
      check("R4 move to implemented bank present", {31'd0, pres}, 32'd1);
      set_bank(8'h01); get(1'b0, 8'hF0, d);
      check("R4 moved byte at 1F0h", {24'd0, d}, 32'hC3);
      move(12'h050, 12'hFE0, mid, dn, pres);
      get(1'b1, 8'hE0, d);
      check("R10 move into bank register", {24'd0, d}, 32'h03);
      move(12'h050, 12'h260, mid, dn, pres);
      check("R10 move to missing bank still done", {31'd0, dn}, 32'd1);
      check("R10 move to missing bank not present", {31'd0, pres}, 32'd0);
      set_bank(8'h02); get(1'b0, 8'h60, d);
      check("R10 missing bank still reads zero", {24'd0, d}, 32'h00);
      set_bank(8'h00); get(1'b0, 8'h60, d);
      check("R10 bank 0 offset 60h unchanged", {24'd0, d}, 32'h99);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal();
      t_access_low();
      t_sfr();
      t_bankreg();
      t_unimpl();
      t_rmw();
      t_move();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule